// File: doc/BRIEF.md
# Refresh Low-Power Mode Sequencer

This block decides the power state of a self-refreshing dynamic memory that presents a static-RAM-style bus. After reset, which stands in for supply becoming valid, it holds the device in an initialization period. It then allows normal operation. It watches the active-low sleep input and the chip-enable input, and it also honours a lock flag that the configuration logic raises once partial refresh has been programmed by software. With these inputs it moves the device into partial-array refresh or deep power-down, and back out of them again.

While the device is initializing or in a low-power state, the block refuses bus accesses. For any row address it reports whether that row is currently kept alive by refresh. All durations are counted in clock cycles. They are derived from a cycles-per-microsecond parameter and from the microsecond lengths of the initialization period and the sleep qualification period.

Top module: `lp_refresh_seq`

## Requirements
- R1: Reset places the block in the initializing state (pwr_state code 0) with ready low. The block moves to normal (code 1) on exactly the INIT_CYC-th rising edge after reset is released, where INIT_CYC = INIT_US * CLK_PER_US.
- R2: In normal state, zz_n sampled low together with ce_n high on QUAL_CYC = ZZ_QUAL_US * CLK_PER_US consecutive edges changes the state on the last of those edges. With sleep_par = 1 the new state is partial refresh (code 2). With sleep_par = 0 it is deep power-down (code 3). After QUAL_CYC-1 such edges the state is still normal.
- R3: The qualification count starts again from zero on any edge where zz_n is high or ce_n is low.
- R4: In partial refresh with sw_par_lock low, zz_n sampled high returns the block to normal on that edge, with ready high.
- R5: In deep power-down, zz_n sampled high moves the block to the initializing state. A full INIT_CYC edges then pass before it reaches normal.
- R6: access_ok follows access_req only in normal state. In every other state a request is ignored and access_ok stays low.
- R7: sw_par_lock sampled high in normal state moves the block to partial refresh on that edge, whatever the level of zz_n. While the lock stays high, partial refresh is held whatever the level of zz_n.
- R8: If the lock and a completed deep power-down qualification arrive on the same edge, the block enters partial refresh and not deep power-down.
- R9: row_refreshed is 1 in normal state and 0 in the initializing state and in deep power-down. In partial refresh it depends on q, the two most significant bits of row_addr, and on par_sel: 000 covers all rows, 001 covers q<3, 010 covers q<2, 011 covers q=0, 100 covers none, 101 covers q>0, 110 covers q>1, and 111 covers q=3.
- R10: ready is high in normal state and low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; stands for supply becoming valid |
| zz_n | input | 1 | Active-low sleep request |
| ce_n | input | 1 | Active-low chip enable |
| sleep_par | input | 1 | Sleep choice: 1 = partial refresh, 0 = deep power-down |
| par_sel | input | 3 | Partial refresh region select |
| sw_par_lock | input | 1 | Partial refresh was programmed by software; the sleep pin no longer controls entry |
| row_addr | input | ROW_AW | Row address to classify |
| access_req | input | 1 | Read or write attempt on the bus |
| access_ok | output | 1 | Attempt is accepted |
| ready | output | 1 | Normal operation is possible |
| pwr_state | output | 2 | 0 init, 1 normal, 2 partial refresh, 3 deep power-down |
| row_refreshed | output | 1 | row_addr is inside the refreshed region |

## Verification
Two events can land on one clock edge. One is the sleep qualifier completing a deep power-down request. The other is the software lock arriving. The bench holds zz_n low with sleep_par cleared for QUAL_CYC-1 edges and raises the lock just before the final qualifying edge. It then requires partial refresh rather than deep power-down, and requires the next edges to hold that state even after zz_n returns high. The same two-event case is covered by a property that any lock seen in normal state is followed by partial refresh.

// File: rtl/lp_refresh_pkg.sv
package lp_refresh_pkg;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_PAR  = 2'd2,
        ST_DPD  = 2'd3
    } pwr_state_e;

    // Region test on the top quarter index of a row.
    // Bottom-anchored fractions keep q <= ~sel[1:0];
    // top-anchored fractions keep q >= sel[1:0]; 100 keeps nothing.
    function automatic logic quarter_kept(input logic [2:0] sel, input logic [1:0] q);
        if (sel == 3'b100)
            return 1'b0;
        else if (sel[2])
            return q >= sel[1:0];
        else
            return q <= ~sel[1:0];
    endfunction

endpackage

// File: rtl/lp_hold_timer.sv
module lp_hold_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lp_region_map.sv
module lp_region_map
    import lp_refresh_pkg::*;
#(
    parameter int ROW_AW = 8
) (
    input  logic [2:0]        par_sel,
    input  logic [ROW_AW-1:0] row_addr,
    output logic              in_region
);
    localparam int QHI = ROW_AW - 1;

    logic [1:0] quarter;
    logic       unused_low;

    assign quarter    = row_addr[QHI -: 2];
    assign unused_low = ^row_addr[QHI-2:0];
    assign in_region  = quarter_kept(par_sel, quarter);
endmodule

// File: rtl/lp_refresh_seq.sv
module lp_refresh_seq
    import lp_refresh_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int INIT_US    = 150,
    parameter int ZZ_QUAL_US = 10,
    parameter int ROW_AW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zz_n,
    input  logic              ce_n,
    input  logic              sleep_par,
    input  logic [2:0]        par_sel,
    input  logic              sw_par_lock,
    input  logic [ROW_AW-1:0] row_addr,
    input  logic              access_req,
    output logic              access_ok,
    output logic              ready,
    output logic [1:0]        pwr_state,
    output logic              row_refreshed
);
    localparam int INIT_CYC = INIT_US * CLK_PER_US;
    localparam int QUAL_CYC = ZZ_QUAL_US * CLK_PER_US;

    pwr_state_e st, st_nxt;
    logic       init_done, qual_done, qual_run, in_region;

    assign qual_run = (st == ST_RUN) && !zz_n && ce_n && !sw_par_lock;

    lp_hold_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_INIT),
        .done (init_done)
    );

    lp_hold_timer #(.LIMIT(QUAL_CYC)) u_qual_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (qual_run),
        .done (qual_done)
    );

    lp_region_map #(.ROW_AW(ROW_AW)) u_region (
        .par_sel   (par_sel),
        .row_addr  (row_addr),
        .in_region (in_region)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_INIT: if (init_done) st_nxt = ST_RUN;
            ST_RUN: begin
                if (sw_par_lock)    st_nxt = ST_PAR;
                else if (qual_done) st_nxt = sleep_par ? ST_PAR : ST_DPD;
            end
            ST_PAR:  if (!sw_par_lock && zz_n) st_nxt = ST_RUN;
            ST_DPD:  if (zz_n) st_nxt = ST_INIT;
            default: st_nxt = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_INIT;
        else     st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            ST_RUN:  row_refreshed = 1'b1;
            ST_PAR:  row_refreshed = in_region;
            default: row_refreshed = 1'b0;
        endcase
    end

    assign pwr_state = st;
    assign ready     = (st == ST_RUN);
    assign access_ok = access_req && (st == ST_RUN);
endmodule

// File: rtl/lp_refresh_seq_chk.sv
module lp_refresh_seq_chk
    import lp_refresh_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       zz_n,
    input logic       ce_n,
    input logic [2:0] par_sel,
    input logic       sw_par_lock,
    input logic       access_req,
    input logic       access_ok,
    input logic       ready,
    input logic [1:0] pwr_state,
    input logic       row_refreshed
);
    p_stay_run_r3: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_RUN && !sw_par_lock && (zz_n || !ce_n)) |=> pwr_state == ST_RUN);

    p_par_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_PAR && zz_n && !sw_par_lock) |=> (pwr_state == ST_RUN && ready));

    p_dpd_reinit_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_DPD && zz_n) |=> pwr_state == ST_INIT);

    p_dpd_no_skip_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_DPD) |=> pwr_state != ST_RUN);

    p_grant_r6: assert property (@(posedge clk) disable iff (rst)
        access_ok |-> (ready && access_req));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_par_lock && pwr_state == ST_PAR) |=> pwr_state == ST_PAR);

    p_lock_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_par_lock && pwr_state == ST_RUN) |=> pwr_state == ST_PAR);

    p_dpd_dark_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_DPD || pwr_state == ST_INIT) |-> !row_refreshed);

    p_none_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == ST_PAR && par_sel == 3'b100) |-> !row_refreshed);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != ST_RUN) |-> !ready);
endmodule

bind lp_refresh_seq lp_refresh_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .zz_n          (zz_n),
    .ce_n          (ce_n),
    .par_sel       (par_sel),
    .sw_par_lock   (sw_par_lock),
    .access_req    (access_req),
    .access_ok     (access_ok),
    .ready         (ready),
    .pwr_state     (pwr_state),
    .row_refreshed (row_refreshed)
);

// File: tb/lp_refresh_seq_bench.sv
module lp_refresh_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int IUS   = 150;
    localparam int QUS   = 10;
    localparam int AW    = 8;
    localparam int INITC = IUS * CPU;
    localparam int QUALC = QUS * CPU;

    // Expected coverage per region select, bit index = top quarter of the row
    localparam logic [3:0] KEEP_TBL [8] = '{
        4'b1111, 4'b0111, 4'b0011, 4'b0001,
        4'b0000, 4'b1110, 4'b1100, 4'b1000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          zz_n = 1'b1, ce_n = 1'b1, sleep_par = 1'b1, sw_par_lock = 1'b0;
    logic [2:0]    par_sel = 3'b000;
    logic [AW-1:0] row_addr = '0;
    logic          access_req = 1'b0;
    logic          access_ok, ready, row_refreshed;
    logic [1:0]    pwr_state;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lp_refresh_seq #(
        .CLK_PER_US(CPU), .INIT_US(IUS), .ZZ_QUAL_US(QUS), .ROW_AW(AW)
    ) u_lp_refresh_seq (
        .clk(clk), .rst(rst), .zz_n(zz_n), .ce_n(ce_n), .sleep_par(sleep_par),
        .par_sel(par_sel), .sw_par_lock(sw_par_lock), .row_addr(row_addr),
        .access_req(access_req), .access_ok(access_ok), .ready(ready),
        .pwr_state(pwr_state), .row_refreshed(row_refreshed)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic power_up;
        rst = 1'b1; sw_par_lock = 1'b0; zz_n = 1'b1; ce_n = 1'b1;
        step(3);
        rst = 1'b0;
        step(INITC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        step(3);
        // R1 R10 R6 R9 reset state
        access_req = 1'b1;
        chk("R1 state in reset", pwr_state, 0);
        chk("R10 ready in reset", ready, 0);
        chk("R6 access in reset", access_ok, 0);
        chk("R9 row in init", row_refreshed, 0);
        rst = 1'b0;
        step(INITC - 1);
        chk("R1 still init one edge early", pwr_state, 0);
        step(1);
        chk("R1 normal after init", pwr_state, 1);
        chk("R10 ready in normal", ready, 1);
        chk("R6 access in normal", access_ok, 1);
        chk("R9 row in normal", row_refreshed, 1);

        // R3 restart by ce_n low mid-qualification
        sleep_par = 1'b1;
        zz_n = 1'b0;
        step(QUALC - 1);
        ce_n = 1'b0;
        step(1);
        ce_n = 1'b1;
        step(QUALC - 1);
        chk("R3 restart after ce_n low", pwr_state, 1);
        zz_n = 1'b1;
        step(1);
        // R3 restart by zz_n high
        zz_n = 1'b0;
        step(QUALC - 1);
        chk("R3 pre-check", pwr_state, 1);
        zz_n = 1'b1;
        step(1);
        zz_n = 1'b0;
        step(QUALC - 1);
        chk("R3 restart after zz_n high", pwr_state, 1);

        // R2 entry into partial refresh on the QUALC-th edge
        step(1);
        chk("R2 partial refresh entry", pwr_state, 2);
        chk("R10 ready in partial", ready, 0);
        chk("R6 access ignored in partial", access_ok, 0);

        // R9 region table walk
        for (int s = 0; s < 8; s++) begin
            for (int q = 0; q < 4; q++) begin
                par_sel  = 3'(s);
                row_addr = {2'(q), 6'b101101};
                #1;
                chk($sformatf("R9 sel=%0d q=%0d", s, q), row_refreshed, int'(KEEP_TBL[s][q]));
            end
        end
        par_sel = 3'b000;

        // R4 exit from partial refresh
        zz_n = 1'b1;
        step(1);
        chk("R4 exit partial", pwr_state, 1);
        chk("R4 ready after exit", ready, 1);

        // R2 deep power-down entry
        sleep_par = 1'b0;
        zz_n = 1'b0;
        step(QUALC - 1);
        chk("R2 deep not yet", pwr_state, 1);
        step(1);
        chk("R2 deep entry", pwr_state, 3);
        chk("R9 row in deep", row_refreshed, 0);
        chk("R6 access ignored in deep", access_ok, 0);

        // R5 exit from deep power-down forces full init
        zz_n = 1'b1;
        step(1);
        chk("R5 reinit entered", pwr_state, 0);
        chk("R10 ready in reinit", ready, 0);
        step(INITC - 1);
        chk("R5 still reinit", pwr_state, 0);
        step(1);
        chk("R5 normal after reinit", pwr_state, 1);

        // R8 lock and deep qualification on the same edge
        sleep_par = 1'b0;
        zz_n = 1'b0;
        step(QUALC - 1);
        sw_par_lock = 1'b1;
        step(1);
        chk("R8 lock beats deep", pwr_state, 2);
        // R7 lock holds partial regardless of zz_n
        zz_n = 1'b1;
        step(5);
        chk("R7 partial held under lock", pwr_state, 2);
        chk("R6 access ignored under lock", access_ok, 0);

        // R7 lock entry with zz_n high, after a fresh power-up
        power_up();
        chk("R1 normal after power-up", pwr_state, 1);
        sw_par_lock = 1'b1;
        step(1);
        chk("R7 lock enters partial", pwr_state, 2);
        zz_n = 1'b0;
        step(2);
        zz_n = 1'b1;
        step(2);
        chk("R7 zz_n toggle ignored", pwr_state, 2);

        report();
    end
endmodule